// File: doc/BRIEF.md
# Deep-Sleep Wakeup Filter

This block decides when outside activity should bring the system out of deep sleep. It watches four wake sources: a bank of GPIO pins, an activity line from each of two serial controllers, and one external interrupt line. When a single-cycle sleep-entry strobe arrives, it stores the present level of every source as a reference. While the system sleeps, a source asks for a wake when its level moves away from that reference.

Each source has its own filter enable. With the filter on, the source is sampled only on a slow tick. The tick is a one-cycle pulse in the fast clock domain that stands for an edge of a nominal 10 kHz RC oscillator. A filtered source wakes the system only after three tick samples in a row agree with each other and differ from the reference. With the filter off, any difference from the reference counts straight away.

GPIO pins take part only while a global GPIO wake enable is set. A pin marked as analog always reads as logic 1 on the digital side, so it can never cause a wake. The wake output is sticky and does not say which pin or source fired. Software finds the cause by reading the pin states afterwards and then clears the output with an acknowledge pulse.

Top module: `wkf_top`

## Requirements
- R1: After reset, `wake_o` is 0.
- R2: When a source's filter is off (its `filt_en_i` bit is 0), a source level that differs from its reference sets `wake_o` on the next rising clock edge.
- R3: When a source's filter is on, `wake_o` rises one clock edge after the third sampling tick whose sample differs from the reference, provided all three samples are equal. There is no wake before that third tick.
- R4: With the filter on, a difference that lasts for fewer than three consecutive tick samples does not set `wake_o`.
- R5: A source whose level equals its reference never sets `wake_o`, whether or not its filter is on.
- R6: GPIO pins cannot set `wake_o` while `gpio_wake_en_i` is 0. Setting the enable while a pin differs from its reference sets `wake_o` on the next edge (unfiltered).
- R7: A pin with its `gpio_analog_i` bit set is read as 1, both for the reference and while sleeping, so toggling it never sets `wake_o`.
- R8: Once set, `wake_o` stays 1 until `wake_ack_i` is pulsed. The acknowledge clears it on the next edge and disarms the block, so no further wake occurs until the next sleep entry.
- R9: `sleep_entry_i` latches a new reference for every source, clears `wake_o` on the next edge, and restarts the sample count. If it arrives in the same cycle as an acknowledge, the sleep entry wins.
- R10: Before the first sleep entry after reset, source activity never sets `wake_o`.
- R11: The `filt_en_i` bits are assigned as follows: bit 0 is the GPIO bank, bit 1 is serial controller 1, bit 2 is serial controller 2, and bit 3 is the interrupt line.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tick_i | input | 1 | One-cycle slow sampling pulse |
| sleep_entry_i | input | 1 | One-cycle strobe; latches references and arms the block |
| wake_ack_i | input | 1 | One-cycle acknowledge; clears the wake output and disarms the block |
| gpio_i | input | NPIN | GPIO pin levels |
| gpio_analog_i | input | NPIN | Per-pin analog-mode flag |
| gpio_wake_en_i | input | 1 | Global enable for GPIO wake |
| sc1_act_i | input | 1 | Serial controller 1 activity line |
| sc2_act_i | input | 1 | Serial controller 2 activity line |
| irq_i | input | 1 | External interrupt line |
| filt_en_i | input | 4 | Per-source filter enables (mapping in R11) |
| wake_o | output | 1 | Sticky wake request |

## Verification
The assertions assume that `sleep_entry_i`, `wake_ack_i` and `tick_i` are single-cycle pulses. They also assume that a tick and a sleep entry in the same cycle resolve in favour of the sleep entry. The bench drives every strobe for exactly one clock, from the falling edge. Before each sleep entry it returns all sources to a known level, so the latched references are known. Ticks are spaced several cycles apart, as a slow oscillator would deliver them, and the filtered cases never pulse a tick together with a sleep entry.

// File: rtl/wkf_pkg.sv
// Package: shared constants for the wakeup filter.
// Assumes: four wake sources, each with one filter-enable bit.
package wkf_pkg;
    localparam int WKF_NSRC   = 4;
    localparam int SRC_GPIO   = 0;
    localparam int SRC_SC1    = 1;
    localparam int SRC_SC2    = 2;
    localparam int SRC_IRQ    = 3;
    localparam int CNT_W      = 2;
    localparam int NEED_SAMP  = 3;
endpackage

// File: rtl/wkf_pin_cond.sv
// Module: wkf_pin_cond
// Presents the digital view of the GPIO pins. A pin in analog mode always
// reads as logic 1.
// Assumes: the analog flags are static while the system sleeps.
module wkf_pin_cond #(
    parameter int NPIN = 8
) (
    input  logic [NPIN-1:0] pin_i,
    input  logic [NPIN-1:0] analog_i,
    output logic [NPIN-1:0] pin_o
);
    // Per-pin force-to-one for analog pins.
    for (genvar g = 0; g < NPIN; g++) begin : g_pin
        assign pin_o[g] = analog_i[g] | pin_i[g];
    end
endmodule

// File: rtl/wkf_chan.sv
// Module: wkf_chan
// One wake source channel, W bits wide. It stores a reference on sleep
// entry and keeps the last three tick samples. It raises trig_o either on a
// raw difference (filter off) or on three equal, differing samples
// (filter on).
// Assumes: sleep_i and tick_i are one-cycle pulses; sleep_i wins over tick_i.
module wkf_chan
    import wkf_pkg::*;
#(
    parameter int W = 1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         tick_i,
    input  logic         sleep_i,
    input  logic         filt_en_i,
    input  logic [W-1:0] in_i,
    output logic         trig_o
);
    localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(NEED_SAMP);

    logic [W-1:0]     ref_q;
    logic [W-1:0]     s0_q, s1_q, s2_q;
    logic [CNT_W-1:0] cnt_q;
    logic [W-1:0]     settled_diff;

    // Reference latch, sample shift register and saturating sample count.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ref_q <= '0;
            s0_q  <= '0;
            s1_q  <= '0;
            s2_q  <= '0;
            cnt_q <= '0;
        end else if (sleep_i) begin
            ref_q <= in_i;
            cnt_q <= '0;
        end else if (tick_i) begin
            s2_q <= s1_q;
            s1_q <= s0_q;
            s0_q <= in_i;
            if (cnt_q != CNT_FULL) cnt_q <= cnt_q + 1'b1;
        end
    end

    // Per-bit test: three equal samples that differ from the reference.
    for (genvar g = 0; g < W; g++) begin : g_bit
        assign settled_diff[g] = (s0_q[g] == s1_q[g]) && (s1_q[g] == s2_q[g])
                                 && (s0_q[g] != ref_q[g]);
    end

    // Select the filtered or the raw comparison.
    always_comb begin
        if (filt_en_i) trig_o = (cnt_q == CNT_FULL) && (|settled_diff);
        else           trig_o = |(in_i ^ ref_q);
    end

    // R9: a sleep entry restarts the sample count.
    p_cnt_restart_r9: assert property (@(posedge clk) disable iff (!rst_n)
        sleep_i |=> (cnt_q == '0));

    // R3: every tick outside sleep entry advances the count until it is full.
    p_cnt_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (tick_i && !sleep_i && cnt_q != CNT_FULL) |=> (cnt_q == $past(cnt_q) + 1'b1));

    // R9: the reference stays fixed between sleep entries.
    p_ref_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !sleep_i |=> $stable(ref_q));
endmodule

// File: rtl/wkf_top.sv
// Module: wkf_top
// Wakeup decision for deep sleep. It combines the GPIO bank, two serial
// activity lines and one interrupt line. Each source has its own optional
// slow-tick filter. The wake output is sticky until acknowledged.
// Assumes: strobes are one-cycle pulses; sleep entry wins over acknowledge.
module wkf_top
    import wkf_pkg::*;
#(
    parameter int NPIN = 8
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                tick_i,
    input  logic                sleep_entry_i,
    input  logic                wake_ack_i,
    input  logic [NPIN-1:0]     gpio_i,
    input  logic [NPIN-1:0]     gpio_analog_i,
    input  logic                gpio_wake_en_i,
    input  logic                sc1_act_i,
    input  logic                sc2_act_i,
    input  logic                irq_i,
    input  logic [WKF_NSRC-1:0] filt_en_i,
    output logic                wake_o
);
    logic [NPIN-1:0]     gpio_dig;
    logic [WKF_NSRC-1:0] src_trig;
    logic                any_trig;
    logic                armed_q;
    logic                wake_q;

    wkf_pin_cond #(.NPIN(NPIN)) u_pin_cond (
        .pin_i    (gpio_i),
        .analog_i (gpio_analog_i),
        .pin_o    (gpio_dig)
    );

    wkf_chan #(.W(NPIN)) u_ch_gpio (
        .clk(clk), .rst_n(rst_n), .tick_i(tick_i), .sleep_i(sleep_entry_i),
        .filt_en_i(filt_en_i[SRC_GPIO]), .in_i(gpio_dig), .trig_o(src_trig[SRC_GPIO])
    );
    wkf_chan #(.W(1)) u_ch_sc1 (
        .clk(clk), .rst_n(rst_n), .tick_i(tick_i), .sleep_i(sleep_entry_i),
        .filt_en_i(filt_en_i[SRC_SC1]), .in_i(sc1_act_i), .trig_o(src_trig[SRC_SC1])
    );
    wkf_chan #(.W(1)) u_ch_sc2 (
        .clk(clk), .rst_n(rst_n), .tick_i(tick_i), .sleep_i(sleep_entry_i),
        .filt_en_i(filt_en_i[SRC_SC2]), .in_i(sc2_act_i), .trig_o(src_trig[SRC_SC2])
    );
    wkf_chan #(.W(1)) u_ch_irq (
        .clk(clk), .rst_n(rst_n), .tick_i(tick_i), .sleep_i(sleep_entry_i),
        .filt_en_i(filt_en_i[SRC_IRQ]), .in_i(irq_i), .trig_o(src_trig[SRC_IRQ])
    );

    // Merge the sources; GPIO counts only while its global enable is set.
    assign any_trig = (src_trig[SRC_GPIO] & gpio_wake_en_i) | src_trig[SRC_SC1]
                    | src_trig[SRC_SC2] | src_trig[SRC_IRQ];

    // Arm on sleep entry, disarm on acknowledge; sticky wake while armed.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            armed_q <= 1'b0;
            wake_q  <= 1'b0;
        end else if (sleep_entry_i) begin
            armed_q <= 1'b1;
            wake_q  <= 1'b0;
        end else if (wake_ack_i) begin
            armed_q <= 1'b0;
            wake_q  <= 1'b0;
        end else if (armed_q && any_trig) begin
            wake_q  <= 1'b1;
        end
    end

    assign wake_o = wake_q;

    // R8: the wake output holds until acknowledged or until the next sleep entry.
    p_wake_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (wake_o && !wake_ack_i && !sleep_entry_i) |=> wake_o);

    // R8: an acknowledge clears the wake output.
    p_ack_clears_r8: assert property (@(posedge clk) disable iff (!rst_n)
        wake_ack_i |=> !wake_o);

    // R9: a sleep entry clears the wake output.
    p_sleep_clears_r9: assert property (@(posedge clk) disable iff (!rst_n)
        sleep_entry_i |=> !wake_o);

    // R10: no wake while the block is disarmed.
    p_idle_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !armed_q |-> !wake_o);
endmodule

// File: tb/wkf_top_tb.sv
module wkf_top_tb;
    localparam int NPIN = 8;

    logic            clk = 1'b0;
    logic            rst_n;
    logic            tick_i, sleep_entry_i, wake_ack_i;
    logic [NPIN-1:0] gpio_i, gpio_analog_i;
    logic            gpio_wake_en_i, sc1_act_i, sc2_act_i, irq_i;
    logic [3:0]      filt_en_i;
    logic            wake_o;

    int checks = 0;
    int errors = 0;

    always #2 clk = ~clk;

    wkf_top #(.NPIN(NPIN)) u_dut (
        .clk(clk), .rst_n(rst_n), .tick_i(tick_i), .sleep_entry_i(sleep_entry_i),
        .wake_ack_i(wake_ack_i), .gpio_i(gpio_i), .gpio_analog_i(gpio_analog_i),
        .gpio_wake_en_i(gpio_wake_en_i), .sc1_act_i(sc1_act_i), .sc2_act_i(sc2_act_i),
        .irq_i(irq_i), .filt_en_i(filt_en_i), .wake_o(wake_o)
    );

    task automatic check(input logic act, input logic exp, input string tag);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: wake_o=%0b expected %0b", tag, act, exp);
        end
    endtask

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic pulse_sleep();
        sleep_entry_i = 1'b1; cyc(1); sleep_entry_i = 1'b0;
    endtask

    task automatic pulse_ack();
        wake_ack_i = 1'b1; cyc(1); wake_ack_i = 1'b0;
    endtask

    task automatic pulse_tick();
        tick_i = 1'b1; cyc(1); tick_i = 1'b0; cyc(3);
    endtask

    task automatic idle_inputs();
        gpio_i = '0; gpio_analog_i = '0; gpio_wake_en_i = 1'b0;
        sc1_act_i = 1'b0; sc2_act_i = 1'b0; irq_i = 1'b0; filt_en_i = '0;
        cyc(1); pulse_ack(); cyc(1);
    endtask

    task automatic t_reset();
        check(wake_o, 1'b0, "R1 reset value");
    endtask

    task automatic t_not_armed();
        irq_i = 1'b1; sc1_act_i = 1'b1; cyc(4);
        check(wake_o, 1'b0, "R10 no wake before first sleep entry");
        idle_inputs();
    endtask

    task automatic t_unfiltered();
        pulse_sleep();
        irq_i = 1'b1; cyc(1);
        check(wake_o, 1'b1, "R2 unfiltered irq wakes next edge");
        irq_i = 1'b0; cyc(3);
        check(wake_o, 1'b1, "R8 wake sticky after source returns");
        pulse_ack();
        check(wake_o, 1'b0, "R8 ack clears wake");
        irq_i = 1'b1; cyc(3);
        check(wake_o, 1'b0, "R8 disarmed after ack");
        idle_inputs();
    endtask

    task automatic t_filtered();
        filt_en_i = 4'b1111;
        pulse_sleep();
        sc1_act_i = 1'b1; cyc(2);
        check(wake_o, 1'b0, "R3 filtered no immediate wake");
        pulse_tick(); pulse_tick();
        check(wake_o, 1'b0, "R3 no wake after two samples");
        tick_i = 1'b1; cyc(1); tick_i = 1'b0;
        check(wake_o, 1'b0, "R3 wake not in third tick cycle");
        cyc(1);
        check(wake_o, 1'b1, "R3 wake one edge after third tick");
        idle_inputs();
    endtask

    task automatic t_glitch();
        filt_en_i = 4'b1111;
        pulse_sleep();
        sc2_act_i = 1'b1;
        pulse_tick(); pulse_tick();
        sc2_act_i = 1'b0;
        pulse_tick(); pulse_tick(); pulse_tick();
        check(wake_o, 1'b0, "R4 two-sample glitch rejected");
        check(wake_o, 1'b0, "R5 samples equal to reference no wake");
        idle_inputs();
        pulse_sleep();
        cyc(4);
        check(wake_o, 1'b0, "R5 unfiltered sources at reference no wake");
        idle_inputs();
    endtask

    task automatic t_mapping();
        filt_en_i = 4'b0100;
        pulse_sleep();
        sc2_act_i = 1'b1; cyc(3);
        check(wake_o, 1'b0, "R11 bit 2 filters serial controller 2");
        sc1_act_i = 1'b1; cyc(1);
        check(wake_o, 1'b1, "R11 serial controller 1 unfiltered");
        idle_inputs();
        filt_en_i = 4'b0001; gpio_wake_en_i = 1'b1;
        pulse_sleep();
        gpio_i = 8'h10; cyc(3);
        check(wake_o, 1'b0, "R11 bit 0 filters GPIO");
        idle_inputs();
    endtask

    task automatic t_gpio_gate();
        pulse_sleep();
        gpio_i = 8'h01; cyc(3);
        check(wake_o, 1'b0, "R6 GPIO blocked without enable");
        gpio_wake_en_i = 1'b1; cyc(1);
        check(wake_o, 1'b1, "R6 GPIO wakes once enabled");
        idle_inputs();
    endtask

    task automatic t_analog();
        gpio_analog_i = 8'h04; gpio_wake_en_i = 1'b1;
        pulse_sleep();
        gpio_i = 8'h04; cyc(2); gpio_i = 8'h00; cyc(2); gpio_i = 8'h04; cyc(2);
        check(wake_o, 1'b0, "R7 analog pin never wakes");
        idle_inputs();
    endtask

    task automatic t_relatch();
        irq_i = 1'b1; cyc(1);
        pulse_sleep(); cyc(3);
        check(wake_o, 1'b0, "R9 new reference equals high level");
        irq_i = 1'b0; cyc(1);
        check(wake_o, 1'b1, "R9 departure from new reference wakes");
        sleep_entry_i = 1'b1; wake_ack_i = 1'b1; cyc(1);
        sleep_entry_i = 1'b0; wake_ack_i = 1'b0;
        check(wake_o, 1'b0, "R9 sleep entry clears wake");
        irq_i = 1'b1; cyc(1);
        check(wake_o, 1'b1, "R9 sleep entry wins over ack and rearms");
        idle_inputs();
    endtask

    initial begin : watchdog
        #200000;
        errors++;
        checks++;
        $display("FAIL watchdog: run hung, actual timeout expected completion");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        rst_n = 1'b0; tick_i = 1'b0; sleep_entry_i = 1'b0; wake_ack_i = 1'b0;
        gpio_i = '0; gpio_analog_i = '0; gpio_wake_en_i = 1'b0;
        sc1_act_i = 1'b0; sc2_act_i = 1'b0; irq_i = 1'b0; filt_en_i = '0;
        cyc(3);
        rst_n = 1'b1;
        cyc(1);
        t_reset();
        t_not_armed();
        t_unfiltered();
        t_filtered();
        t_glitch();
        t_mapping();
        t_gpio_gate();
        t_analog();
        t_relatch();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule